// File: doc/BRIEF.md
# Presence-Detect Memory Two-Wire Target

This block is a two-wire (I2C) target that presents a 256-byte configuration memory to a host controller. The bus address is fixed in its upper four bits. Three strap inputs set its lower three bits, so several modules can share one bus. The host can write single bytes or a run of bytes. It can read from the current pointer, set the pointer and then read, or stream any number of bytes with automatic pointer advance.

The lower half of the memory holds factory contents. It can never be changed. Byte 63 of that half is a checksum over the bytes below it, computed when the contents load. The upper half is open to the host, except while the write-protect input is high. Every write that actually stores data starts an internal programming period once the stop condition arrives. For the length of that period the target does not respond to its own address, so the host polls until an acknowledge returns.

Both bus lines are sampled on a fast system clock through two-stage synchronizers. The data output is an open-drain pull-down enable. The length of the programming period is a parameter, so a bench can shorten it.

Top module: `presence_rom_i2c`

## Requirements
- R1: While reset is asserted and directly after it, `sda_pull_o` is low. After reset, byte 0 reads 0x80 and byte 1 reads 0x08.
- R2: The target acknowledges an address byte by pulling SDA low in the ninth clock. It does this only when the first seven bits received, MSB first, equal {1010, `sel_i[2:0]`}. The eighth bit selects the direction: 1 is read, 0 is write. Any other address is not acknowledged, and the rest of that transfer is ignored.
- R3: After reset, these contents load: bytes 2 to 62 hold (37*i+11) mod 256; bytes 64 to 127 hold i XOR 0x5A; bytes 128 to 255 hold 0xFF. Byte 63 holds the low 8 bits of the sum of bytes 0 to 62.
- R4: In a write transfer, the first byte after the address sets the byte pointer. The next byte is stored at that pointer. A later random read of that location returns it.
- R5: A data byte aimed at bytes 0 to 127 is acknowledged but not stored. It starts no programming period.
- R6: While `wp_i` is high, a data byte aimed at bytes 128 to 255 is acknowledged but not stored. It starts no programming period.
- R7: After the stop condition that ends a transfer with at least one stored byte, the target refuses every address byte for BUSY_CYCLES clocks. After that it acknowledges again.
- R8: A read transfer without a pointer byte returns the byte one past the last byte written or read.
- R9: A sequential read advances the pointer after each byte and wraps from 255 to 0. A not-acknowledge from the host ends the read, and SDA is released.
- R10: Read data goes out MSB first. The pull-down only switches on while SCL is low.
- R11: Several data bytes in one write transfer are stored at consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sel_i | input | 3 | Address strap inputs, low address bits |
| wp_i | input | 1 | Write protect for the upper half, active high |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The addressing logic sees all 128 seven-bit addresses with one strap value. Exactly one of them must be acknowledged, which separates a correct compare from one that ignores or misorders a strap bit. A second strap value confirms that the straps actually steer the match. A single 257-byte streaming read covers the whole memory. It separates the locked pattern, the XOR pattern, the blank upper half and the checksum, and its last byte shows the wrap back to byte 0. Writes go to a locked byte, to a protected upper byte and to an open upper byte. Each is followed at once by an address probe, which separates stored writes (refused while programming) from discarded ones (acknowledged at once).

// File: rtl/pdt_pkg.sv
`timescale 1ns/1ps
package pdt_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MEM_DEPTH = 256;
  localparam int unsigned MEM_AW    = $clog2(MEM_DEPTH);
  localparam int unsigned SUM_IDX   = 63;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WORD, ST_WORD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_WAIT
  } pdt_state_e;

  // factory pattern without the checksum byte
  function automatic logic [BYTE_W-1:0] pdt_base(input int unsigned idx);
    if (idx == 0) return 8'h80;
    if (idx == 1) return 8'h08;
    if (idx < SUM_IDX) return 8'((idx * 37 + 11) % 256);
    if (idx < MEM_DEPTH / 2) return 8'((idx ^ 32'h5A) % 256);
    return 8'hFF;
  endfunction

  function automatic logic [BYTE_W-1:0] pdt_sum();
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int unsigned k = 0; k < SUM_IDX; k++) acc = acc + pdt_base(k);
    return acc;
  endfunction

  function automatic logic [BYTE_W-1:0] pdt_fill(input int unsigned idx);
    if (idx == SUM_IDX) return pdt_sum();
    return pdt_base(idx);
  endfunction
endpackage

// File: rtl/pdt_sync.sv
`timescale 1ns/1ps
module pdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pdt_busy.sv
`timescale 1ns/1ps
module pdt_busy #(
  parameter int unsigned CYCLES = 3_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm)               cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pdt_array.sv
`timescale 1ns/1ps
module pdt_array
  import pdt_pkg::*;
#(
  parameter int unsigned DEPTH = MEM_DEPTH,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_req,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wp,
  output logic              wr_commit
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  // upper half only, and only while protect is low
  assign wr_commit = wr_req & wr_addr[AW-1] & ~wp;
  assign rd_data   = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++) mem_q[i] <= pdt_fill(i);
    end else if (wr_commit) begin
      mem_q[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/pdt_ctrl.sv
`timescale 1ns/1ps
module pdt_ctrl
  import pdt_pkg::*;
#(
  parameter logic [3:0]  DEV_ID = 4'b1010,
  parameter int unsigned AW     = MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        sel,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wr_commit,
  output logic [AW-1:0]     ptr,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_data,
  output logic              busy_arm,
  output logic              sda_oe,
  output pdt_state_e        state
);
  pdt_state_e        st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, tx_q, tx_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              rw_q, rw_d, oe_q, oe_d, pend_q, pend_d, mack_q, mack_d;
  logic              rx_bit, rx_end;

  assign rx_bit = scl_rise & (cnt_q < 4'd8);
  assign rx_end = scl_fall & (cnt_q == 4'd8);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    ptr_d    = ptr_q;
    rw_d     = rw_q;
    oe_d     = oe_q;
    pend_d   = pend_q;
    mack_d   = mack_q;
    wr_req   = 1'b0;
    busy_arm = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
      if (pend_q) begin
        busy_arm = 1'b1;
        pend_d   = 1'b0;
      end
    end else if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (rx_bit) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (rx_end) begin
            if (sh_q[7:1] == {DEV_ID, sel} && !busy) begin
              st_d = ST_ADDR_ACK;
              oe_d = 1'b1;
              rw_d = sh_q[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_WORD: begin
          if (rx_bit) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (rx_end) begin
            ptr_d = sh_q[AW-1:0];
            oe_d  = 1'b1;
            st_d  = ST_WORD_ACK;
          end
        end
        ST_WDATA: begin
          if (rx_bit) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (rx_end) begin
            wr_req = 1'b1;
            if (wr_commit) pend_d = 1'b1;
            ptr_d = ptr_q + 1'b1;
            oe_d  = 1'b1;
            st_d  = ST_WDATA_ACK;
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d = rd_data;
              oe_d = ~rd_data[BYTE_W-1];
              st_d = ST_RDATA;
            end else begin
              oe_d = 1'b0;
              st_d = ST_WORD;
            end
          end
        end
        ST_WORD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d  = 1'b0;
              ptr_d = ptr_q + 1'b1;
              st_d  = ST_RDATA_ACK;
            end else begin
              oe_d = ~tx_q[BYTE_W-2];
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d  = rd_data;
              oe_d  = ~rd_data[BYTE_W-1];
              cnt_d = '0;
              st_d  = ST_RDATA;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
      pend_q <= pend_d;
      mack_q <= mack_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;
  assign state   = st_q;
endmodule

// File: rtl/presence_rom_i2c.sv
`timescale 1ns/1ps
module presence_rom_i2c
  import pdt_pkg::*;
#(
  parameter logic [3:0]  DEV_ID      = 4'b1010,
  parameter int unsigned BUSY_CYCLES = 3_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_sync;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              busy, busy_arm, wr_req, wr_commit;
  logic [MEM_AW-1:0] ptr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  pdt_state_e        state;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  pdt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk_i), .rst_n(rst_n_sync), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  pdt_busy #(.CYCLES(BUSY_CYCLES)) i_busy (
    .clk(clk_i), .rst_n(rst_n_sync), .arm(busy_arm), .busy(busy)
  );

  pdt_array #(.DEPTH(MEM_DEPTH), .AW(MEM_AW)) i_array (
    .clk(clk_i), .rst_n(rst_n_sync), .rd_addr(ptr), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(ptr), .wr_data(wr_data), .wp(wp_i),
    .wr_commit(wr_commit)
  );

  pdt_ctrl #(.DEV_ID(DEV_ID), .AW(MEM_AW)) i_ctrl (
    .clk(clk_i), .rst_n(rst_n_sync), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det), .sel(sel_i),
    .busy(busy), .rd_data(rd_data), .wr_commit(wr_commit), .ptr(ptr),
    .wr_req(wr_req), .wr_data(wr_data), .busy_arm(busy_arm),
    .sda_oe(sda_pull_o), .state(state)
  );
endmodule

// File: rtl/presence_rom_i2c_chk.sv
`timescale 1ns/1ps
module presence_rom_i2c_chk
  import pdt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       stop_det,
  input logic       busy,
  input logic       sda_oe,
  input pdt_state_e state
);
  // R7: the programming period only begins right after a stop condition
  assert_busy_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R7: no address acknowledge while programming
  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> state != ST_ADDR_ACK);

  // R10: the pull-down engages only with SCL low
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R10: the pull-down engages only just after a falling SCL edge
  assert_pull_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R9: a stop condition always frees the line
  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind presence_rom_i2c presence_rom_i2c_chk i_chk (
  .clk(clk_i), .rst_n(rst_n_sync), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_det(stop_det), .busy(busy), .sda_oe(sda_pull_o), .state(state)
);

// File: tb/test_presence_rom_i2c.sv
`timescale 1ns/1ps
module test_presence_rom_i2c;
  localparam int BUSY = 600;
  localparam int Q    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       m_low = 1'b0;
  logic [2:0] sel = 3'b101;
  logic       wp = 1'b0;
  logic       sda_pull;
  wire        sda_line = ~(m_low | sda_pull);
  int         n_tests = 0;
  int         n_fail = 0;
  logic       ack;
  logic [7:0] rx;

  always #2.5 clk = ~clk;

  presence_rom_i2c #(.BUSY_CYCLES(BUSY)) i_presence_rom_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sel_i(sel), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  function automatic logic [7:0] exp_byte(input int i);
    int s;
    if (i == 63) begin
      s = 0;
      for (int k = 0; k < 63; k++) s += exp_byte(k);
      return 8'(s % 256);
    end
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h08;
    if (i < 63) return 8'((37 * i + 11) % 256);
    if (i < 128) return 8'(i ^ 8'h5A);
    return 8'hFF;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q);
    m_low = 1'b1; waitq(Q); scl_m = 1'b0; waitq(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q); m_low = 1'b0; waitq(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; waitq(Q); scl_m = 1'b1; waitq(Q); scl_m = 1'b0; waitq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q / 2);
    b = sda_line; waitq(Q / 2); scl_m = 1'b0; waitq(Q);
  endtask

  task automatic send(input logic [7:0] d, output logic a);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    a = ~b;
  endtask

  task automatic recv(input logic more, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~more);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, sel, rw};
  endfunction

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    logic k;
    i2c_start(); send(dev(1'b0), k); send(a, k);
    i2c_start(); send(dev(1'b1), k); recv(1'b0, d); i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    waitq(4);
    check("R1 reset release", sda_pull, 0);
    rst_n = 1'b1;
    waitq(6);
    check("R1 after reset", sda_pull, 0);

    // R2: address sweep with strap 101
    for (int a = 0; a < 128; a++) begin
      i2c_start(); send({a[6:0], 1'b0}, ack); i2c_stop();
      check("R2 sweep", ack, (a == 7'b1010101) ? 1 : 0);
    end
    sel = 3'b010;
    i2c_start(); send(8'hA4, ack); i2c_stop();
    check("R2 new strap match", ack, 1);
    i2c_start(); send(8'hAA, ack); i2c_stop();
    check("R2 old strap refused", ack, 0);

    // R1 R3 R9 R10: stream all bytes plus one from 0
    i2c_start(); send(dev(1'b0), ack); send(8'h00, ack);
    i2c_start(); send(dev(1'b1), ack);
    check("R2 read address ack", ack, 1);
    for (int i = 0; i < 257; i++) begin
      recv(i < 256, rx);
      if (i < 2) check("R1 id byte", rx, exp_byte(i));
      else if (i == 63) check("R3 checksum", rx, exp_byte(63));
      else if (i == 256) check("R9 wrap to 0", rx, 8'h80);
      else check("R3 contents", rx, exp_byte(i));
    end
    check("R9 released after nack", sda_pull, 0);
    i2c_stop();

    // R4 R7: store one byte, probe busy
    i2c_start(); send(dev(1'b0), ack); send(8'd130, ack); send(8'h3C, ack);
    check("R4 data ack", ack, 1);
    i2c_stop();
    i2c_start(); send(dev(1'b0), ack); i2c_stop();
    check("R7 busy refuses", ack, 0);
    waitq(BUSY + 50);
    i2c_start(); send(dev(1'b0), ack); i2c_stop();
    check("R7 ack after busy", ack, 1);
    rand_read(8'd130, rx);
    check("R4 readback", rx, 8'h3C);

    // R11 R8: two bytes in one transfer, then current-address reads
    i2c_start(); send(dev(1'b0), ack); send(8'd200, ack);
    send(8'hA1, ack); send(8'hB2, ack); i2c_stop();
    waitq(BUSY + 50);
    rand_read(8'd200, rx);
    check("R11 first byte", rx, 8'hA1);
    i2c_start(); send(dev(1'b1), ack); recv(1'b0, rx); i2c_stop();
    check("R8 R11 current read", rx, 8'hB2);
    i2c_start(); send(dev(1'b1), ack); recv(1'b0, rx); i2c_stop();
    check("R8 next current read", rx, 8'hFF);

    // R5: locked lower half
    i2c_start(); send(dev(1'b0), ack); send(8'd10, ack); send(8'h77, ack);
    check("R5 locked ack", ack, 1);
    i2c_stop();
    i2c_start(); send(dev(1'b0), ack); i2c_stop();
    check("R5 no busy", ack, 1);
    rand_read(8'd10, rx);
    check("R5 unchanged", rx, exp_byte(10));

    // R6: protected upper half
    wp = 1'b1;
    i2c_start(); send(dev(1'b0), ack); send(8'd140, ack); send(8'h55, ack);
    check("R6 protected ack", ack, 1);
    i2c_stop();
    i2c_start(); send(dev(1'b0), ack); i2c_stop();
    check("R6 no busy", ack, 1);
    rand_read(8'd140, rx);
    check("R6 unchanged", rx, 8'hFF);
    wp = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule